// File: doc/BRIEF.md
# Sampling-Point Tune and Timing Mode Control Register

This block is a 32-bit control word for a card host interface. It holds the bus timing mode code in its low bits and a 6-bit sampling-point tune value a byte higher. Software stores a new tune value and, in the same write, sets a self-clearing update flag. The block then spends a fixed number of cycles moving that value into the receive sampling delay logic. It raises a one-cycle load strobe, with the applied delay code, at the end of that time. The update flag reads back as 1 for the whole transfer, so software polls the word until the flag drops. The block does not contain the delay line itself.

A sequencer runs the transfer with three named states. ST_IDLE moves to ST_WAIT when a tune write arrives with the update flag set. ST_WAIT moves to ST_COMMIT after LOAD_LAT-1 cycles. ST_COMMIT drives the load strobe for one cycle and returns to ST_IDLE. While the sequencer is away from ST_IDLE, the tune byte of the word is locked. The delay logic honours only 43 tap positions, so a stored value above 42 reaches it wrapped back toward zero. Tuning software keeps to values 0 to 39.

A separate combinational helper suggests a mode code from the card clock frequency in kHz and a double-data-rate flag. Software can copy that suggestion into the mode field.

Top module: `tune_mode_ctl`

## Requirements
- R1: The read word carries the mode code in bits 2:0, the tune value in bits 13:8 and the update flag in bit 15. Every other bit reads 0.
- R2: After reset the word reads 0: mode 0, tune 0 and update flag clear. The load strobe is low and the applied delay code is 0.
- R3: A write with byte enable 0 set stores bits 2:0 verbatim as the mode, including the code 6. If byte enable 1 is clear, the same write leaves the tune value and the update flag unchanged, whatever the other data bits hold. A write with byte enable 1 set and byte enable 0 clear leaves the mode unchanged.
- R4: A write in ST_IDLE with byte enable 1 set and data bit 15 at 1 stores the tune value. The update flag then reads 1 for exactly LOAD_LAT (4) cycles, starting the cycle after the write, and reads 0 afterwards.
- R5: The load strobe is high only in the last of those LOAD_LAT cycles. In that cycle the applied delay code shows the new value. The code holds its value at all other times.
- R6: While the update flag reads 1, writes to byte 1 are ignored: the tune value, the flag and the transfer timing are unchanged. A byte 0 write in the same period still updates the mode.
- R7: A byte 1 write in ST_IDLE with data bit 15 at 0 stores the tune value without starting a transfer. The load strobe stays low and the applied code keeps its old value.
- R8: The applied delay code equals the tune value when the tune value is 42 or less, and equals the tune value minus 43 when it is above 42. For example, 43 gives 0, 45 gives 2 and 63 gives 20.
- R9: The mode suggestion is 0 for a clock at or below 26000 kHz. Up to and including 52000 kHz it is 3 with the DDR flag set and 2 without it. Above 52000 kHz it is 5 with the DDR flag set and 4 without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_be | input | 4 | Byte enables: byte 0 holds the mode, byte 1 holds the tune value and update flag |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control word |
| card_clk_khz | input | 20 | Card clock frequency in kHz, used for the mode suggestion |
| ddr_en | input | 1 | Double-data-rate flag for the mode suggestion |
| mode_hint | output | 3 | Suggested mode code |
| mode_out | output | 3 | Stored mode code, sent to the bus timing logic |
| dly_code | output | 6 | Applied sampling delay code |
| dly_load | output | 1 | One-cycle strobe that loads dly_code into the delay logic |

## Verification
A sequencer that is stuck or counts wrong shows at the ports within a handful of cycles. The bit-15 flag stays high past its fourth cycle, drops early, or falls without a load strobe in the cycle before. The bench checks all of these on the exact cycle. A tune byte that locks incorrectly shows on the first read after the write, through bits 13:8. A bad wrap or a bad capture shows as a wrong dly_code in the single strobe cycle. Mode suggestions are checked at each threshold and one kHz past it, in the cycle the inputs change.

// File: rtl/tune_mode_pkg.sv
package tune_mode_pkg;

    localparam int TUNE_W = 6;
    localparam int MODE_W = 3;

    // bit positions inside the 32-bit control word
    localparam int MODE_LSB = 0;
    localparam int TUNE_LSB = 8;
    localparam int UPD_BIT  = 15;

    // timing mode codes
    localparam logic [MODE_W-1:0] MD_LEGACY = 3'd0;
    localparam logic [MODE_W-1:0] MD_SDR    = 3'd2;
    localparam logic [MODE_W-1:0] MD_DDR    = 3'd3;
    localparam logic [MODE_W-1:0] MD_HS_SDR = 3'd4;
    localparam logic [MODE_W-1:0] MD_HS_DDR = 3'd5;
    localparam logic [MODE_W-1:0] MD_HS_STB = 3'd6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_COMMIT
    } load_st_e;

    // delay logic honours LIMIT taps; larger codes fold back toward zero
    function automatic logic [TUNE_W-1:0] fold_tune(
        input logic [TUNE_W-1:0] t,
        input logic [TUNE_W-1:0] limit
    );
        if (t >= limit) return t - limit;
        return t;
    endfunction

endpackage

// File: rtl/tmc_mode_pick.sv
module tmc_mode_pick
    import tune_mode_pkg::*;
#(
    parameter int FREQ_W   = 20,
    parameter int SLOW_KHZ = 26000,
    parameter int MID_KHZ  = 52000
) (
    input  logic [FREQ_W-1:0] freq_khz,
    input  logic              ddr,
    output logic [MODE_W-1:0] mode
);

    localparam logic [FREQ_W-1:0] SLOW_LIM = FREQ_W'(SLOW_KHZ);
    localparam logic [FREQ_W-1:0] MID_LIM  = FREQ_W'(MID_KHZ);

    always_comb begin
        if (freq_khz <= SLOW_LIM)     mode = MD_LEGACY;
        else if (freq_khz <= MID_LIM) mode = ddr ? MD_DDR : MD_SDR;
        else                          mode = ddr ? MD_HS_DDR : MD_HS_SDR;
    end

endmodule

// File: rtl/tmc_load_fsm.sv
module tmc_load_fsm
    import tune_mode_pkg::*;
#(
    parameter int LOAD_LAT   = 4,
    parameter int TUNE_LIMIT = 43
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [TUNE_W-1:0] tune,
    output logic              busy,
    output logic              load,
    output logic [TUNE_W-1:0] code
);

    localparam int                CNT_W = $clog2(LOAD_LAT) + 1;
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(LOAD_LAT - 2);
    localparam logic [TUNE_W-1:0] LIM   = TUNE_W'(TUNE_LIMIT);

    load_st_e          state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [TUNE_W-1:0] code_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (launch) state_d = ST_WAIT;
            ST_WAIT:   if (cnt_q == LAST) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register, wait counter and captured code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == ST_WAIT) ? cnt_q + 1'b1 : '0;
            if (state_q == ST_WAIT && state_d == ST_COMMIT)
                code_q <= fold_tune(tune, LIM);
        end
    end

    // outputs
    always_comb begin
        busy = (state_q != ST_IDLE);
        load = (state_q == ST_COMMIT);
        code = code_q;
    end

endmodule

// File: rtl/tune_mode_ctl.sv
module tune_mode_ctl
    import tune_mode_pkg::*;
#(
    parameter int LOAD_LAT   = 4,
    parameter int TUNE_LIMIT = 43,
    parameter int FREQ_W     = 20,
    parameter int SLOW_KHZ   = 26000,
    parameter int MID_KHZ    = 52000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_be,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    input  logic [FREQ_W-1:0] card_clk_khz,
    input  logic              ddr_en,
    output logic [MODE_W-1:0] mode_hint,
    output logic [MODE_W-1:0] mode_out,
    output logic [TUNE_W-1:0] dly_code,
    output logic              dly_load
);

    logic [MODE_W-1:0] mode_q;
    logic [TUNE_W-1:0] tune_q;
    logic              busy;
    logic              tune_wr;
    logic              launch;
    logic              unused_bits;

    assign tune_wr     = wr_en && wr_be[1] && !busy;
    assign launch      = tune_wr && wr_data[UPD_BIT];
    assign unused_bits = ^{wr_data[31:16], wr_data[14], wr_data[7:3], wr_be[3:2]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            tune_q <= '0;
        end else begin
            if (wr_en && wr_be[0])
                mode_q <= wr_data[MODE_LSB +: MODE_W];
            if (tune_wr)
                tune_q <= wr_data[TUNE_LSB +: TUNE_W];
        end
    end

    always_comb begin
        rd_data                     = '0;
        rd_data[MODE_LSB +: MODE_W] = mode_q;
        rd_data[TUNE_LSB +: TUNE_W] = tune_q;
        rd_data[UPD_BIT]            = busy;
    end

    assign mode_out = mode_q;

    tmc_load_fsm #(
        .LOAD_LAT   (LOAD_LAT),
        .TUNE_LIMIT (TUNE_LIMIT)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .tune   (tune_q),
        .busy   (busy),
        .load   (dly_load),
        .code   (dly_code)
    );

    tmc_mode_pick #(
        .FREQ_W   (FREQ_W),
        .SLOW_KHZ (SLOW_KHZ),
        .MID_KHZ  (MID_KHZ)
    ) u_pick (
        .freq_khz (card_clk_khz),
        .ddr      (ddr_en),
        .mode     (mode_hint)
    );

endmodule

// File: rtl/tune_mode_ctl_chk.sv
module tune_mode_ctl_chk #(
    parameter int LOAD_LAT   = 4,
    parameter int TUNE_LIMIT = 43,
    parameter int FREQ_W     = 20,
    parameter int SLOW_KHZ   = 26000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [3:0]        wr_be,
    input logic [31:0]       rd_data,
    input logic [FREQ_W-1:0] card_clk_khz,
    input logic [2:0]        mode_hint,
    input logic [5:0]        dly_code,
    input logic              dly_load
);

    logic [15:0] busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n)          busy_run <= '0;
        else if (rd_data[15]) busy_run <= busy_run + 16'd1;
        else                  busy_run <= '0;
    end

    p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[15] |-> (busy_run < 16'(LOAD_LAT)));

    p_load_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dly_load |-> rd_data[15]);

    p_fall_after_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[15]) |-> $past(dly_load));

    p_tune_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[15] && busy_run != 16'd0) |-> $stable(rd_data[13:8]));

    p_mode_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_be[0]) |=> $stable(rd_data[2:0]));

    p_code_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dly_load |-> (dly_code < 6'(TUNE_LIMIT)));

    p_slow_hint_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (card_clk_khz <= FREQ_W'(SLOW_KHZ)) |-> (mode_hint == 3'd0));

    p_zero_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[31:16] == 16'd0) && (rd_data[14] == 1'b0) && (rd_data[7:3] == 5'd0));

endmodule

bind tune_mode_ctl tune_mode_ctl_chk #(
    .LOAD_LAT   (LOAD_LAT),
    .TUNE_LIMIT (TUNE_LIMIT),
    .FREQ_W     (FREQ_W),
    .SLOW_KHZ   (SLOW_KHZ)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_be        (wr_be),
    .rd_data      (rd_data),
    .card_clk_khz (card_clk_khz),
    .mode_hint    (mode_hint),
    .dly_code     (dly_code),
    .dly_load     (dly_load)
);

// File: tb/tune_mode_ctl_tb.sv
`timescale 1ns/1ps
module tune_mode_ctl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = 4'd0;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] rd_data;
    logic [19:0] card_clk_khz = 20'd0;
    logic        ddr_en = 1'b0;
    logic [2:0]  mode_hint;
    logic [2:0]  mode_out;
    logic [5:0]  dly_code;
    logic        dly_load;

    always #5 clk = ~clk;

    tune_mode_ctl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_be        (wr_be),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .card_clk_khz (card_clk_khz),
        .ddr_en       (ddr_en),
        .mode_hint    (mode_hint),
        .mode_out     (mode_out),
        .dly_code     (dly_code),
        .dly_load     (dly_load)
    );

    typedef struct {
        int          cyc;
        int          sel;   // 0 rd_data, 1 dly_code, 2 dly_load, 3 mode_hint, 4 mode_out
        logic [31:0] val;
        string       req;
    } item_t;

    item_t sb[$];
    int    cycle = 0;
    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;

    // bench model of the stored fields
    logic [2:0] mode_m = 3'd0;
    logic [5:0] tune_m = 6'd0;
    logic [5:0] code_m = 6'd0;

    function automatic logic [31:0] word(input logic [2:0] m, input logic [5:0] t, input bit u);
        return {16'd0, u, 1'b0, t, 5'd0, m};
    endfunction

    task automatic push(input int c, input int s, input logic [31:0] v, input string r);
        item_t it;
        it.cyc = c; it.sel = s; it.val = v; it.req = r;
        sb.push_back(it);
    endtask

    // monitor: compare every item due this cycle, shortly after the edge
    always @(posedge clk) begin
        cycle = cycle + 1;
        #2;
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].cyc == cycle) begin
                logic [31:0] act;
                case (sb[i].sel)
                    0: act = rd_data;
                    1: act = {26'd0, dly_code};
                    2: act = {31'd0, dly_load};
                    3: act = {29'd0, mode_hint};
                    default: act = {29'd0, mode_out};
                endcase
                total++;
                if (act !== sb[i].val) begin
                    bad++;
                    $display("FAIL %s cycle %0d sel %0d actual=%h expected=%h",
                             sb[i].req, cycle, sb[i].sel, act, sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    task automatic drive_wr(input logic [3:0] be, input logic [31:0] d, output int e);
        @(negedge clk);
        e = cycle + 1;
        wr_en = 1'b1; wr_be = be; wr_data = d;
    endtask

    task automatic release_bus();
        @(negedge clk);
        wr_en = 1'b0; wr_be = 4'd0; wr_data = 32'd0;
    endtask

    // tune write with the update flag from idle; checks busy window, strobe and fold
    task automatic launch(input logic [5:0] t, input logic [5:0] exp_code, input string r);
        int e;
        drive_wr(4'b0010, {16'd0, 1'b1, 1'b0, t, 8'hA7}, e);
        tune_m = t;
        for (int k = 0; k < 4; k++) push(e + k, 0, word(mode_m, tune_m, 1'b1), "R4");
        push(e + 4, 0, word(mode_m, tune_m, 1'b0), "R4");
        push(e + 2, 2, 32'd0, "R5");
        push(e + 2, 1, {26'd0, code_m}, "R5");
        push(e + 3, 2, 32'd1, "R5");
        push(e + 3, 1, {26'd0, exp_code}, r);
        push(e + 4, 2, 32'd0, "R5");
        code_m = exp_code;
        release_bus();
        repeat (5) @(negedge clk);
    endtask

    task automatic hint(input int f, input bit d, input logic [2:0] exp);
        @(negedge clk);
        card_clk_khz = 20'(f); ddr_en = d;
        push(cycle + 1, 3, {29'd0, exp}, "R9");
        @(negedge clk);
    endtask

    initial begin : watchdog
        wait (cycle >= 5000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=<5000 cycles", cycle);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        int e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset values
        push(cycle + 1, 0, 32'd0, "R2");
        push(cycle + 1, 1, 32'd0, "R2");
        push(cycle + 1, 2, 32'd0, "R2");
        @(negedge clk);

        // R1 / R3: mode write through byte 0 only, other data bits set
        drive_wr(4'b0001, 32'hFFFF_FF05, e);
        mode_m = 3'd5;
        push(e, 0, word(mode_m, tune_m, 1'b0), "R1");
        push(e, 4, 32'd5, "R3");
        push(e + 1, 2, 32'd0, "R3");
        release_bus();
        repeat (2) @(negedge clk);

        // R4 / R5 / R6: launch 20, then a locked write while busy
        drive_wr(4'b0011, 32'h0000_9405, e);
        tune_m = 6'd20;
        push(e,     0, word(3'd5, 6'd20, 1'b1), "R4");
        push(e + 1, 0, word(3'd5, 6'd20, 1'b1), "R4");
        push(e + 3, 2, 32'd1, "R5");
        push(e + 3, 1, 32'd20, "R5");
        push(e + 2, 2, 32'd0, "R5");
        release_bus();
        drive_wr(4'b0011, 32'h0000_8702, e);   // at e_first+2
        mode_m = 3'd2;
        push(e,     0, word(3'd2, 6'd20, 1'b1), "R6");
        push(e + 1, 0, word(3'd2, 6'd20, 1'b1), "R6");
        push(e + 2, 0, word(3'd2, 6'd20, 1'b0), "R6");
        push(e + 2, 2, 32'd0, "R6");
        push(e + 3, 2, 32'd0, "R6");
        push(e + 3, 1, 32'd20, "R6");
        push(e + 6, 0, word(3'd2, 6'd20, 1'b0), "R6");
        code_m = 6'd20;
        release_bus();
        repeat (6) @(negedge clk);

        // R7: tune write without update flag
        drive_wr(4'b0010, 32'h0000_0900, e);
        tune_m = 6'd9;
        push(e, 0, word(mode_m, tune_m, 1'b0), "R7");
        for (int k = 0; k < 6; k++) push(e + k, 2, 32'd0, "R7");
        push(e + 5, 1, {26'd0, code_m}, "R7");
        release_bus();
        repeat (6) @(negedge clk);

        // R3: byte 0 write of code 6 with bit 15 in data, byte 1 disabled
        drive_wr(4'b0001, 32'h0000_BF06, e);
        mode_m = 3'd6;
        push(e, 0, word(mode_m, tune_m, 1'b0), "R3");
        for (int k = 0; k < 5; k++) push(e + k, 2, 32'd0, "R3");
        push(e + 4, 0, word(mode_m, tune_m, 1'b0), "R3");
        release_bus();
        repeat (5) @(negedge clk);

        // R8: fold of codes above 42
        launch(6'd39, 6'd39, "R8");
        launch(6'd42, 6'd42, "R8");
        launch(6'd43, 6'd0,  "R8");
        launch(6'd45, 6'd2,  "R8");
        launch(6'd63, 6'd20, "R8");
        launch(6'd0,  6'd0,  "R8");

        // R9: mode suggestion thresholds
        hint(0,     1'b1, 3'd0);
        hint(26000, 1'b1, 3'd0);
        hint(26001, 1'b0, 3'd2);
        hint(26001, 1'b1, 3'd3);
        hint(52000, 1'b1, 3'd3);
        hint(52000, 1'b0, 3'd2);
        hint(52001, 1'b0, 3'd4);
        hint(52001, 1'b1, 3'd5);
        hint(200000, 1'b0, 3'd4);

        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            bad += sb.size(); total += sb.size();
            $display("FAIL scoreboard actual=%0d pending expected=0", sb.size());
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule